// File: doc/BRIEF.md
# External Interrupt Line Controller

This block conditions three external interrupt pins for a downstream interrupt controller. Each pin is brought into the clock domain through a two-stage synchronizer. A per-line trigger selection then detects a high level, a low level, a rising edge or a falling edge on the synchronized pin. Each line can be masked on its own. The result is always presented downstream as an active-high request. Low levels are inverted, and falling edges become a latched flag whose assertion is a rising transition.

Software reaches each line through an 8-bit control field on a small word-addressed write/read bus with byte enables. In edge modes a pending flag holds the event until software writes 1 to it. In level modes the same bit simply reports whether the input is currently active.

A strap sampled while reset is asserted chooses the register layout. In split layout each line has its own word. In packed layout all three fields share word 0, and the lines appear in reverse byte order.

Top module: `extirq_ctrl`

## Requirements
- R1: In split layout (strap low at reset), line i's field is in bits 7:0 of word address i (0, 1, 2), written when `bus_be[0]` is set; word address 3 reads 0 and upper read bits are 0.
- R2: Field layout: bit 0 pending/active status, bit 4 clock-select (read/write), bit 5 enable, bits 7:6 trigger type; bits 3:1 read 0.
- R3: Trigger type 2'b10 is rising edge and 2'b11 falling edge. The matching pin transition sets pending three clock edges after the pin changes, and pending stays set after the pin returns.
- R4: With enable 0 the line's request stays low, but an edge still latches pending; setting enable then raises the request.
- R5: Writing 1 to bit 0 clears pending in edge modes; such a write has no effect in level modes.
- R6: Trigger type 2'b00 is high level and 2'b01 low level. The request equals enable AND the active level, two clock edges after the pin changes, and bit 0 reads the active level.
- R7: An edge detected in the same cycle as a write-1 clear keeps pending set.
- R8: A write that changes the trigger type clears pending, and an edge coincident with that write is ignored.
- R9: In packed layout (strap high at reset), line i occupies byte lane 2-i of word 0, written only where `bus_be[2-i]` is set. Other lanes are left unchanged, and other word addresses read 0.
- R10: After reset all fields read 0 and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_strap | input | 1 | Layout select, captured while reset is low (1 = packed) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pins_in | input | 3 | Asynchronous external interrupt pins |
| irq_req | output | 3 | Active-high requests to the downstream controller |

## Verification
A pin change reaches a level-mode request after two rising edges, and reaches an edge-mode pending flag after three. Register writes take effect at the edge that samples the strobe, and reads are combinational. The bench changes every input on a falling edge and counts whole periods to the cycle an output is due. For the latency requirements it checks one period early that the output has not yet moved. For the clear and type-change collisions it places the write so that its sampling edge is the one where the synchronized transition is first compared.

// File: rtl/extirq_ctrl.sv
module extirq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shared_strap,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [2:0]  pins_in,
  output logic [2:0]  irq_req
);
  localparam int NL = 3;

  logic          mode_q;
  logic [NL-1:0] s1_q, s2_q, prv_q;
  logic [1:0]    age_q;
  logic [NL-1:0][7:0] fld;

  wire unused_hi = ^bus_wdata[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= shared_strap;
      s1_q   <= '0;
      s2_q   <= '0;
      prv_q  <= '0;
      age_q  <= '0;
    end else begin
      s1_q  <= pins_in;
      s2_q  <= s1_q;
      prv_q <= s2_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_line
    localparam int LANE = NL - 1 - g;
    logic       pend_q, cks_q, en_q;
    logic [1:0] typ_q;
    logic [7:0] wb;
    logic       hit, retype, act, edg, clr;

    assign wb     = mode_q ? bus_wdata[8*LANE +: 8] : bus_wdata[7:0];
    assign hit    = bus_wr && (mode_q ? (bus_addr == 2'd0 && bus_be[LANE])
                                      : (bus_addr == 2'(g) && bus_be[0]));
    assign retype = hit && (wb[7:6] != typ_q);
    assign clr    = hit && wb[0];
    assign act    = s2_q[g] ^ typ_q[0];
    assign edg    = typ_q[1] && !retype &&
                    (typ_q[0] ? (prv_q[g] && !s2_q[g]) : (s2_q[g] && !prv_q[g]));
    wire unused_b = ^wb[3:1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        cks_q  <= 1'b0;
        en_q   <= 1'b0;
        typ_q  <= 2'b00;
      end else begin
        if (hit) {typ_q, en_q, cks_q} <= wb[7:4];
        pend_q <= (retype || !typ_q[1]) ? 1'b0 : (edg || (pend_q && !clr));
      end
    end

    assign irq_req[g] = en_q && (typ_q[1] ? pend_q : act);
    assign fld[g]     = {typ_q, en_q, cks_q, 3'b000, typ_q[1] ? pend_q : act};

    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (typ_q[1] && pend_q && !clr && !retype) |=> pend_q);
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (typ_q[1] && clr && !edg) |=> !pend_q);
    p_retype_r8: assert property (@(posedge clk) disable iff (!rst_n)
      retype |=> !pend_q);
    p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!typ_q[1] && en_q && age_q == 2'd3) |->
      (irq_req[g] == ($past(pins_in[g], 2) ^ typ_q[0])));
  end

  always_comb begin
    bus_rdata = '0;
    if (mode_q) begin
      if (bus_addr == 2'd0) bus_rdata = {8'h00, fld[0], fld[1], fld[2]};
    end else begin
      case (bus_addr)
        2'd0:    bus_rdata = {24'h0, fld[0]};
        2'd1:    bus_rdata = {24'h0, fld[1]};
        2'd2:    bus_rdata = {24'h0, fld[2]};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, strap = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0]  pins = 0, irq;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  extirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .shared_strap(strap), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pins_in(pins), .irq_req(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 0; strap = s; pins = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  task automatic t_reset;
    chk("R10 irq", 32'(irq), 0);
    rdchk("R10 line0", 0, 0);
    rdchk("R10 line1", 1, 0);
    rdchk("R10 line2", 2, 0);
    rdchk("R1 unmapped", 3, 0);
  endtask

  task automatic t_layout;
    wr(1, 4'b0001, 32'hFFFF_FFFF);
    rdchk("R2 field bits", 1, 32'h0000_00F0);
    wr(1, 4'b1110, 32'h0000_0000);
    rdchk("R1 be0 gates write", 1, 32'h0000_00F0);
    wr(1, 4'b0001, 0);
    rdchk("R2 restore", 1, 0);
  endtask

  task automatic t_level_high;
    wr(0, 1, 32'h20);
    pins[0] = 1;
    tick(1); chk("R6 high early", 32'(irq[0]), 0);
    tick(1); chk("R6 high due", 32'(irq[0]), 1);
    rdchk("R6 active bit", 0, 32'h21);
    pins[0] = 0;
    tick(2); chk("R6 high release", 32'(irq[0]), 0);
  endtask

  task automatic t_level_low;
    wr(1, 1, 32'h60);
    chk("R6 low inverted", 32'(irq[1]), 1);
    pins[1] = 1;
    tick(2); chk("R6 low release", 32'(irq[1]), 0);
    wr(1, 1, 0);
  endtask

  task automatic t_rising;
    wr(2, 1, 32'hA0);
    pins[2] = 1;
    tick(2); chk("R3 rise early", 32'(irq[2]), 0);
    tick(1); chk("R3 rise due", 32'(irq[2]), 1);
    pins[2] = 0;
    tick(4); chk("R3 latched", 32'(irq[2]), 1);
    rdchk("R3 pending read", 2, 32'hA1);
  endtask

  task automatic t_w1c;
    wr(2, 1, 32'hA1);
    chk("R5 clear irq", 32'(irq[2]), 0);
    rdchk("R5 clear read", 2, 32'hA0);
    wr(0, 1, 32'h21);
    rdchk("R5 level ignores w1c", 0, 32'h20);
    chk("R5 level irq", 32'(irq[0]), 0);
  endtask

  task automatic t_falling;
    wr(2, 1, 32'hE0);
    pins[2] = 1;
    tick(4); chk("R3 fall ignores rise", 32'(irq[2]), 0);
    pins[2] = 0;
    tick(3); chk("R3 fall due", 32'(irq[2]), 1);
    wr(2, 1, 32'hE1);
    chk("R5 fall clear", 32'(irq[2]), 0);
  endtask

  task automatic t_mask;
    wr(2, 1, 32'h80);
    pins[2] = 1;
    tick(4); chk("R4 masked irq", 32'(irq[2]), 0);
    rdchk("R4 pending while masked", 2, 32'h81);
    wr(2, 1, 32'hA0);
    chk("R4 unmask raises", 32'(irq[2]), 1);
    wr(2, 1, 32'hA1);
    pins[2] = 0;
    tick(3);
  endtask

  task automatic t_collision;
    pins[2] = 1;
    tick(4); chk("R7 setup pending", 32'(irq[2]), 1);
    pins[2] = 0;
    tick(3);
    pins[2] = 1;
    @(negedge clk);
    wr(2, 1, 32'hA1);
    chk("R7 edge wins irq", 32'(irq[2]), 1);
    rdchk("R7 edge wins read", 2, 32'hA1);
    wr(2, 1, 32'hA1);
    chk("R7 later clear", 32'(irq[2]), 0);
  endtask

  task automatic t_retype;
    pins[2] = 0;
    tick(3);
    pins[2] = 1;
    @(negedge clk);
    wr(2, 1, 32'hE0);
    tick(3); chk("R8 coincident edge dropped", 32'(irq[2]), 0);
    rdchk("R8 read after retype", 2, 32'hE0);
    pins[2] = 0;
    tick(3); chk("R8 new type works", 32'(irq[2]), 1);
  endtask

  task automatic t_packed;
    do_reset(1);
    chk("R10 packed irq", 32'(irq), 0);
    rdchk("R10 packed word", 0, 0);
    wr(0, 4'b0100, 32'h0020_0000);
    wr(0, 4'b0001, 32'hFFFF_FFA0);
    rdchk("R9 lanes", 0, 32'h0020_00A0);
    rdchk("R9 other word", 1, 0);
    pins[0] = 1;
    tick(2); chk("R9 line0 lane2", 32'(irq[0]), 1);
    pins[2] = 1;
    tick(3); chk("R9 line2 lane0", 32'(irq[2]), 1);
    rdchk("R9 status", 0, 32'h0021_00A1);
  endtask

  initial begin
    do_reset(0);
    t_reset();
    t_layout();
    t_level_high();
    t_level_low();
    t_rising();
    t_w1c();
    t_falling();
    t_mask();
    t_collision();
    t_retype();
    t_packed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule